// File: doc/BRIEF.md
# I2C Receiver Acknowledge Controller

This block runs the acknowledge slot of an I2C receiver. It serves a slave that takes in an address or a data byte, and a master that reads data. It works from sampled SCL and SDA lines on one system clock. It counts SCL rising edges inside each byte and raises a flag while the acknowledge slot is open. In that slot it pulls SDA low for ACK or leaves it released for NACK. Outputs are pull-down enables, because both lines are open-drain.

The response level comes from one of two software bits. A remaining-byte budget selects between them. While the budget is non-zero, a per-byte bit decides. Once the budget reaches zero, a separate end-of-budget bit decides instead. Optional hold enables keep SCL low after a matching address, or after a received data byte, so that software can pick the response. Software then pulses a release strobe. SDA takes the chosen level first, and SCL is let go one clock later.

START and STOP detection, address comparison and arbitration are done elsewhere. This block receives a START indication and an address-match strobe from those units.

Top module: `i2c_ack_ctrl`

## Requirements
- R1: `ack_time` goes high one clock after the 8th SCL falling edge of a byte is sampled, and low one clock after the 9th SCL rising edge is sampled. An SCL edge is a change of `scl_in` between two consecutive clocks. Bits are counted by SCL rising edges after START.
- R2: For a data byte (any byte after the first one following START) while `bytes_left` is non-zero, the level comes from `ack_dt`. A value of 0 asserts `sda_pd` (ACK) and a value of 1 leaves it deasserted (NACK). `ack_end` has no effect in this case.
- R3: For a data byte while `bytes_left` is zero, the level comes from `ack_end` with the same encoding (0 = ACK, 1 = NACK), and `ack_dt` has no effect.
- R4: For the first byte after START (the address byte), the level comes from `ack_dt` only if `addr_match` pulsed during that byte. Without a match, `sda_pd` stays deasserted (NACK) and SCL is never held, whatever `ack_dt` and `addr_hold_en` are.
- R5: With `addr_hold_en` set and a matched address byte, `scl_pd` asserts one clock after the 8th falling edge and stays asserted until release. `sda_pd` stays deasserted during this hold.
- R6: With `wr_hold_en` set, every data byte holds SCL in the same way.
- R7: During a hold, a `release_i` pulse places the level on `sda_pd` at that clock, using the software bits as they are at that moment. `scl_pd` deasserts one clock later.
- R8: `sda_pd` deasserts one clock after the 9th SCL falling edge is sampled.
- R9: `bytes_load` loads `bytes_din` into `bytes_left`. The budget decreases by one at the 9th falling edge of a data byte that was ACKed. It never decreases for a NACKed byte or an address byte, and it stays at zero rather than wrapping.
- R10: `start_det` resets the bit count, releases both pull-downs, clears `ack_time` and the address-match memory, and marks the next byte as an address byte. This applies even in the middle of a byte.
- R11: `sda_pd` only becomes asserted while `ack_time` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronized SCL line level |
| sda_in | input | 1 | Synchronized SDA line level (unused by the ACK logic) |
| start_det | input | 1 | One-clock START / repeated-START indication |
| addr_match | input | 1 | One-clock pulse: the address byte matched |
| ack_dt | input | 1 | Per-byte response bit (0 ACK, 1 NACK) |
| ack_end | input | 1 | Response bit used when the budget is zero |
| addr_hold_en | input | 1 | Hold SCL after a matched address |
| wr_hold_en | input | 1 | Hold SCL after each data byte |
| release_i | input | 1 | Software pulse that ends a hold |
| bytes_load | input | 1 | Load strobe for the byte budget |
| bytes_din | input | CNT_W | Value loaded into the byte budget |
| sda_pd | output | 1 | SDA pull-down enable |
| scl_pd | output | 1 | SCL pull-down enable (hold) |
| ack_time | output | 1 | Acknowledge slot in progress |
| holding | output | 1 | Waiting for a software release |
| bytes_left | output | CNT_W | Remaining-byte budget |

## Verification
The bench sends byte streams that switch the level source between the per-byte bit and the end-of-budget bit. In each case the unused bit is set to the opposite value, so a wrong selection shows up as a flipped SDA level. Address bytes are sent with and without a match pulse. These runs separate the forced NACK from a software NACK and show that an unmatched address is never held. Holds are tested with the software bit changed during the stretch, which proves the level is taken at release and not at the 8th edge. A START in the middle of a byte, followed by a full byte, shows that the edge count restarts.

// File: rtl/i2c_ack_pkg.sv
package i2c_ack_pkg;

  typedef enum logic [1:0] {
    DRV_IDLE  = 2'd0,
    DRV_HOLD  = 2'd1,
    DRV_LETGO = 2'd2
  } drv_state_e;

  // 1 means pull SDA low (ACK)
  function automatic logic ack_pull(
    input logic addr_phase,
    input logic matched,
    input logic cnt_zero,
    input logic dt_bit,
    input logic end_bit
  );
    logic pull;
    if (addr_phase) pull = matched & ~dt_bit;
    else if (cnt_zero) pull = ~end_bit;
    else pull = ~dt_bit;
    return pull;
  endfunction

  function automatic logic hold_wanted(
    input logic addr_phase,
    input logic matched,
    input logic addr_hold,
    input logic data_hold
  );
    return addr_phase ? (addr_hold & matched) : data_hold;
  endfunction

endpackage

// File: rtl/ack_bit_counter.sv
module ack_bit_counter #(
  parameter int BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic start_det,
  output logic fall_last,
  output logic rise_slot,
  output logic fall_slot,
  output logic addr_phase,
  output logic ack_time
);
  localparam int SLOT = BITS + 1;
  localparam int RC_W = $clog2(SLOT + 1);

  logic            scl_q;
  logic [RC_W-1:0] rcnt;
  logic            scl_rise;
  logic            scl_fall;

  assign scl_rise  = scl_in & ~scl_q;
  assign scl_fall  = ~scl_in & scl_q;
  assign fall_last = scl_fall && (rcnt == RC_W'(BITS));
  assign rise_slot = scl_rise && (rcnt == RC_W'(BITS));
  assign fall_slot = scl_fall && (rcnt == RC_W'(SLOT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q      <= 1'b1;
      rcnt       <= '0;
      addr_phase <= 1'b1;
      ack_time   <= 1'b0;
    end else begin
      scl_q <= scl_in;
      if (start_det) begin
        rcnt       <= '0;
        addr_phase <= 1'b1;
        ack_time   <= 1'b0;
      end else begin
        if (scl_rise && rcnt < RC_W'(SLOT)) rcnt <= rcnt + 1'b1;
        if (fall_slot) begin
          rcnt       <= '0;
          addr_phase <= 1'b0;
        end
        if (fall_last) ack_time <= 1'b1;
        else if (rise_slot) ack_time <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ack_byte_budget.sv
module ack_byte_budget #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] din,
  input  logic             dec,
  output logic [CNT_W-1:0] left,
  output logic             is_zero
);
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  assign is_zero = (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left <= '0;
    else if (load) left <= din;
    else if (dec) left <= step_down(left);
  end
endmodule

// File: rtl/ack_line_driver.sv
module ack_line_driver
  import i2c_ack_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic fall_last,
  input  logic fall_slot,
  input  logic addr_phase,
  input  logic addr_match,
  input  logic cnt_zero,
  input  logic ack_dt,
  input  logic ack_end,
  input  logic addr_hold_en,
  input  logic wr_hold_en,
  input  logic release_i,
  output logic sda_pd,
  output logic scl_pd,
  output logic holding
);
  drv_state_e state;
  logic       match_q;
  logic       matched_now;
  logic       pull_lvl;
  logic       want_hold;

  assign matched_now = match_q | addr_match;
  assign pull_lvl    = ack_pull(addr_phase, matched_now, cnt_zero, ack_dt, ack_end);
  assign want_hold   = hold_wanted(addr_phase, matched_now, addr_hold_en, wr_hold_en);
  assign holding     = (state == DRV_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= DRV_IDLE;
      match_q <= 1'b0;
      sda_pd  <= 1'b0;
      scl_pd  <= 1'b0;
    end else if (start_det) begin
      state   <= DRV_IDLE;
      match_q <= 1'b0;
      sda_pd  <= 1'b0;
      scl_pd  <= 1'b0;
    end else begin
      if (addr_match) match_q <= 1'b1;
      unique case (state)
        DRV_IDLE: begin
          if (fall_last) begin
            if (want_hold) begin
              scl_pd <= 1'b1;
              state  <= DRV_HOLD;
            end else begin
              sda_pd <= pull_lvl;
            end
          end else if (fall_slot) begin
            sda_pd <= 1'b0;
          end
        end
        DRV_HOLD: begin
          if (release_i) begin
            sda_pd <= pull_lvl;
            state  <= DRV_LETGO;
          end
        end
        DRV_LETGO: begin
          scl_pd <= 1'b0;
          state  <= DRV_IDLE;
        end
        default: state <= DRV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_ack_ctrl.sv
module i2c_ack_ctrl #(
  parameter int BITS  = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             start_det,
  input  logic             addr_match,
  input  logic             ack_dt,
  input  logic             ack_end,
  input  logic             addr_hold_en,
  input  logic             wr_hold_en,
  input  logic             release_i,
  input  logic             bytes_load,
  input  logic [CNT_W-1:0] bytes_din,
  output logic             sda_pd,
  output logic             scl_pd,
  output logic             ack_time,
  output logic             holding,
  output logic [CNT_W-1:0] bytes_left
);
  // named internal events, observed by the checker
  logic fall_last_w;
  logic rise_slot_w;
  logic fall_slot_w;
  logic addr_phase_w;
  logic cnt_zero_w;
  logic dec_w;
  logic sda_unused;

  assign sda_unused = sda_in;
  assign dec_w      = fall_slot_w & ~addr_phase_w & sda_pd & ~start_det;

  ack_bit_counter #(.BITS(BITS)) u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_in),
    .start_det  (start_det),
    .fall_last  (fall_last_w),
    .rise_slot  (rise_slot_w),
    .fall_slot  (fall_slot_w),
    .addr_phase (addr_phase_w),
    .ack_time   (ack_time)
  );

  ack_byte_budget #(.CNT_W(CNT_W)) u_budget (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (bytes_load),
    .din     (bytes_din),
    .dec     (dec_w),
    .left    (bytes_left),
    .is_zero (cnt_zero_w)
  );

  ack_line_driver u_drv (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_det    (start_det),
    .fall_last    (fall_last_w),
    .fall_slot    (fall_slot_w),
    .addr_phase   (addr_phase_w),
    .addr_match   (addr_match),
    .cnt_zero     (cnt_zero_w),
    .ack_dt       (ack_dt),
    .ack_end      (ack_end),
    .addr_hold_en (addr_hold_en),
    .wr_hold_en   (wr_hold_en),
    .release_i    (release_i),
    .sda_pd       (sda_pd),
    .scl_pd       (scl_pd),
    .holding      (holding)
  );
endmodule

// File: rtl/i2c_ack_ctrl_chk.sv
module i2c_ack_ctrl_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_det,
  input logic             bytes_load,
  input logic             sda_pd,
  input logic             scl_pd,
  input logic             ack_time,
  input logic [CNT_W-1:0] bytes_left,
  input logic             fall_last,
  input logic             rise_slot,
  input logic             fall_slot,
  input logic             dec
);
  // R1
  ack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_last && !start_det |=> ack_time);
  // R1
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_slot |=> !ack_time);
  // R8
  sda_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_slot |=> !sda_pd);
  // R7
  sda_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_pd) && !$past(start_det) |-> $stable(sda_pd));
  // R5
  hold_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pd |-> ack_time);
  // R10
  start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pd && !scl_pd && !ack_time);
  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec && !bytes_load |=> $stable(bytes_left));
  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec && !bytes_load && bytes_left != '0 |=> bytes_left == $past(bytes_left) - 1'b1);
  // R9
  cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec && !bytes_load && bytes_left == '0 |=> bytes_left == '0);
  // R11
  sda_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pd) |-> ack_time);
endmodule

bind i2c_ack_ctrl i2c_ack_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_det  (start_det),
  .bytes_load (bytes_load),
  .sda_pd     (sda_pd),
  .scl_pd     (scl_pd),
  .ack_time   (ack_time),
  .bytes_left (bytes_left),
  .fall_last  (fall_last_w),
  .rise_slot  (rise_slot_w),
  .fall_slot  (fall_slot_w),
  .dec        (dec_w)
);

// File: tb/i2c_ack_ctrl_tb.sv
`timescale 1ns/1ps
module i2c_ack_ctrl_tb;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1;
  logic sda_tx = 1'b1;
  logic start_det = 1'b0;
  logic addr_match = 1'b0;
  logic ack_dt = 1'b0;
  logic ack_end = 1'b0;
  logic addr_hold_en = 1'b0;
  logic wr_hold_en = 1'b0;
  logic release_i = 1'b0;
  logic bytes_load = 1'b0;
  logic [CNT_W-1:0] bytes_din = '0;
  logic sda_pd, scl_pd, ack_time, holding;
  logic [CNT_W-1:0] bytes_left;
  logic scl_in, sda_in;

  // open-drain wired lines
  assign scl_in = scl_drv & ~scl_pd;
  assign sda_in = sda_tx & ~sda_pd;

  int checks = 0;
  int errors = 0;
  bit exp_q[$];

  always #2 clk = ~clk;

  i2c_ack_ctrl #(.BITS(8), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .start_det(start_det), .addr_match(addr_match), .ack_dt(ack_dt),
    .ack_end(ack_end), .addr_hold_en(addr_hold_en), .wr_hold_en(wr_hold_en),
    .release_i(release_i), .bytes_load(bytes_load), .bytes_din(bytes_din),
    .sda_pd(sda_pd), .scl_pd(scl_pd), .ack_time(ack_time),
    .holding(holding), .bytes_left(bytes_left)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic load_budget(input int v);
    @(negedge clk);
    bytes_din  = CNT_W'(v);
    bytes_load = 1'b1;
    @(negedge clk);
    bytes_load = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk);
    sda_tx  = 1'b1;
    scl_drv = 1'b1;
    @(negedge clk) start_det = 1'b1;
    @(negedge clk) start_det = 1'b0;
    sda_tx = 1'b0;
    @(negedge clk) scl_drv = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] d, input int n, input bit match);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk);
      sda_tx = d[i];
      if (match && i == 1) addr_match = 1'b1;
      @(negedge clk);
      addr_match = 1'b0;
      @(negedge clk);
      scl_drv = 1'b1;
      repeat (4) @(negedge clk);
      scl_drv = 1'b0;
    end
  endtask

  // driver: pushes the expected pull level, plays the 9 clocks
  task automatic send_byte(input logic [7:0] d, input bit match, input bit exp_pull,
                           input bit exp_hold, input bit chg, input bit chg_val,
                           input string tag);
    exp_q.push_back(exp_pull);
    send_bits(d, 8, match);
    repeat (3) @(negedge clk);
    sda_tx = 1'b1;
    chk(ack_time == 1'b1, "R1 set after 8th fall", int'(ack_time), 1);
    if (exp_hold) begin
      chk(scl_pd == 1'b1, {tag, " hold asserted"}, int'(scl_pd), 1);
      chk(sda_pd == 1'b0, "R7 sda idle during hold", int'(sda_pd), 0);
      if (chg) ack_dt = chg_val;
      repeat (2) @(negedge clk);
      chk(scl_pd == 1'b1, {tag, " hold kept"}, int'(scl_pd), 1);
      release_i = 1'b1;
      @(negedge clk);
      release_i = 1'b0;
      chk(sda_pd == exp_pull, "R7 level at release", int'(sda_pd), int'(exp_pull));
      chk(scl_pd == 1'b1, "R7 scl still held", int'(scl_pd), 1);
      @(negedge clk);
      chk(scl_pd == 1'b0, "R7 scl let go", int'(scl_pd), 0);
    end else begin
      chk(scl_pd == 1'b0, {tag, " no hold"}, int'(scl_pd), 0);
    end
    scl_drv = 1'b1;
    while (!scl_in) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(ack_time == 1'b0, "R1 clear after 9th rise", int'(ack_time), 0);
    repeat (2) @(negedge clk);
    scl_drv = 1'b0;
    repeat (2) @(negedge clk);
    chk(sda_pd == 1'b0, "R8 sda free after 9th fall", int'(sda_pd), 0);
  endtask

  // monitor: compares the SDA pull in each slot with the queue
  initial begin
    wait (rst_n);
    forever begin
      @(negedge ack_time);
      @(negedge clk);
      if (exp_q.size() == 0) begin
        chk(1'b0, "scoreboard unexpected slot", int'(sda_pd), -1);
      end else begin
        automatic bit e = exp_q.pop_front();
        chk(sda_pd == e, "scoreboard slot level", int'(sda_pd), int'(e));
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sda_pd == 1'b0, "reset sda_pd", int'(sda_pd), 0);
    chk(scl_pd == 1'b0, "reset scl_pd", int'(scl_pd), 0);
    chk(ack_time == 1'b0, "R1 reset ack_time", int'(ack_time), 0);
    chk(bytes_left == '0, "R9 reset budget", int'(bytes_left), 0);

    load_budget(3);
    chk(bytes_left == 8'd3, "R9 load", int'(bytes_left), 3);

    // R4 matched address, ACK from ack_dt
    do_start();
    ack_dt = 1'b0; ack_end = 1'b1;
    send_byte(8'hA4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
    chk(bytes_left == 8'd3, "R9 no step on address", int'(bytes_left), 3);

    // R2 data, budget non-zero: ack_dt=0 -> ACK though ack_end=1
    send_byte(8'h5A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
    chk(bytes_left == 8'd2, "R9 step on ACK", int'(bytes_left), 2);

    // R2 ack_dt=1 -> NACK though ack_end=0
    ack_dt = 1'b1; ack_end = 1'b0;
    send_byte(8'hC3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    chk(bytes_left == 8'd2, "R9 no step on NACK", int'(bytes_left), 2);

    // R6 data hold, software flips ack_dt to ACK during the hold
    wr_hold_en = 1'b1;
    send_byte(8'h0F, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
    chk(bytes_left == 8'd1, "R9 step after hold", int'(bytes_left), 1);
    wr_hold_en = 1'b0;

    ack_dt = 1'b0;
    send_byte(8'hF0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
    chk(bytes_left == 8'd0, "R9 reach zero", int'(bytes_left), 0);

    // R3 budget zero: ack_end=1 -> NACK though ack_dt=0
    ack_end = 1'b1; ack_dt = 1'b0;
    send_byte(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    // R3 ack_end=0 -> ACK though ack_dt=1
    ack_end = 1'b0; ack_dt = 1'b1;
    send_byte(8'h22, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    chk(bytes_left == 8'd0, "R9 saturate at zero", int'(bytes_left), 0);

    // R4 unmatched address: NACK, no hold even with addr_hold_en
    do_start();
    ack_dt = 1'b0; addr_hold_en = 1'b1;
    send_byte(8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4");

    // R5 matched address with hold, software picks NACK during hold
    do_start();
    ack_dt = 1'b0;
    send_byte(8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R5");
    addr_hold_en = 1'b0;

    // R10 START in the middle of a byte
    do_start();
    send_bits(8'hFF, 4, 1'b0);
    repeat (2) @(negedge clk);
    do_start();
    chk(sda_pd == 1'b0 && scl_pd == 1'b0, "R10 lines free", int'({sda_pd, scl_pd}), 0);
    chk(ack_time == 1'b0, "R10 ack_time clear", int'(ack_time), 0);
    ack_dt = 1'b0;
    send_byte(8'h96, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R10");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule